// File: doc/BRIEF.md
# Programmable Countdown Interrupt Timer

This block is a register-mapped countdown timer that raises an interrupt request after a programmed number of divided clock periods. Software programs a configuration register holding an 8-bit vector, a mask flag and a mode field, and selects a clock divider through a 4-bit code. Writing a nonzero initial count starts the countdown, and writing zero stops it. A live current-count register can be read at any time, so software can work out how many ticks have elapsed by subtracting it from the initial count.

Each time the counter steps from one to zero, the block emits a one-cycle request carrying the programmed vector, unless the mask flag is set. In periodic mode the counter reloads from the initial count and keeps running. In one-shot mode it parks at zero and stays silent until the initial count is written again. Writes take effect on the clock edge at which `bus_wr` is sampled high. Reads are combinational from `bus_addr`.

Top module: `cdt_timer`

## Requirements
- R1: The configuration register sits at byte offset 0x320. Vector in bits 7:0, mask in bit 16, mode in bits 18:17 (01 periodic, any other value one-shot). All other bits read as 0.
- R2: The divider code register sits at offset 0x3E0. Only bits 3, 1 and 0 are stored; every other bit reads as 0.
- R3: Writing a nonzero value to the initial-count register (offset 0x380) loads the current count on that edge and starts the countdown. Writing zero clears the current count and stops the timer, so no request follows.
- R4: Divider codes map as 0x0=/2, 0x1=/4, 0x2=/8, 0x3=/16, 0x8=/32, 0x9=/64, 0xA=/128, 0xB=/1. The first decrement lands exactly D cycles after the initial-count write edge, and later decrements follow every D cycles.
- R5: In periodic mode the count steps from 1 straight back to the initial count. Requests therefore fall every N*D cycles after the write (N = initial count).
- R6: The current count (offset 0x390) reads the live value, and initial minus current gives elapsed ticks. Writes to offset 0x390 are ignored.
- R7: With the mask bit set, the counter still counts and reloads, but no request is raised.
- R8: In one-shot mode the counter holds at zero after firing and raises nothing more until the initial count is written again.
- R9: `irq_valid` is high for one cycle, N*D cycles after the write edge, with `irq_vector` equal to the configured vector.
- R10: After reset the configuration reads 0x0001_0000 (masked, one-shot, vector 0), and the initial count, current count and divider code all read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the prescaler source |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Byte offset of the register accessed |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq_valid | output | 1 | One-cycle interrupt request |
| irq_vector | output | 8 | Vector accompanying the request |

## Verification
All eight divider codes are swept with the same initial count, and the current count is sampled one cycle before and one cycle after the expected first decrement. This separates a wrong code mapping from a prescaler that is not restarted by the write. One-shot, periodic and masked-periodic runs are compared against a queue of expected request cycles and vectors: a request that is missing, extra, late or carries the wrong vector is each reported. Stopping a run mid-count, re-arming after a one-shot and writing the read-only count register cover the stop, re-arm and ignore paths.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
    parameter int ADDR_W      = 12;
    parameter int DATA_W      = 32;
    parameter int VEC_W       = 8;
    parameter int DIV_LOG_MAX = 7;
    localparam int PRE_W      = DIV_LOG_MAX;

    localparam logic [ADDR_W-1:0] OFS_CFG  = 12'h320;
    localparam logic [ADDR_W-1:0] OFS_INIT = 12'h380;
    localparam logic [ADDR_W-1:0] OFS_CUR  = 12'h390;
    localparam logic [ADDR_W-1:0] OFS_DIV  = 12'h3E0;

    localparam int CFG_MASK_BIT = 16;
    localparam int CFG_MODE_LSB = 17;
    localparam logic [1:0] MODE_PERIODIC = 2'b01;

    typedef struct packed {
        logic [1:0]       mode;
        logic             mask;
        logic [VEC_W-1:0] vec;
    } cfg_t;

    // Compressed code {b3,b1,b0}: 7 means divide by 1, k otherwise means 2^(k+1).
    // Returns the terminal value of the prescaler (divisor minus one).
    function automatic logic [PRE_W-1:0] div_limit(input logic [2:0] code);
        if (code == 3'b111) return '0;
        return PRE_W'((1 << (int'(code) + 1)) - 1);
    endfunction
endpackage

// File: rtl/cdt_regs.sv
module cdt_regs #(
    parameter int CNT_W = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [cdt_pkg::ADDR_W-1:0]  bus_addr,
    input  logic                        bus_wr,
    input  logic [cdt_pkg::DATA_W-1:0]  bus_wdata,
    input  logic [CNT_W-1:0]            cur_count,
    output cdt_pkg::cfg_t               cfg,
    output logic [CNT_W-1:0]            init_cnt,
    output logic [2:0]                  div_code,
    output logic                        init_wr,
    output logic [CNT_W-1:0]            init_wdata,
    output logic [cdt_pkg::DATA_W-1:0]  bus_rdata
);
    import cdt_pkg::*;

    typedef struct packed {
        cfg_t             cfg;
        logic [CNT_W-1:0] init;
        logic [2:0]       div;
    } reg_st_t;

    reg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (bus_wr) begin
            if (bus_addr == OFS_CFG) begin
                st_d.cfg.vec  = bus_wdata[VEC_W-1:0];
                st_d.cfg.mask = bus_wdata[CFG_MASK_BIT];
                st_d.cfg.mode = bus_wdata[CFG_MODE_LSB +: 2];
            end
            if (bus_addr == OFS_INIT) begin
                st_d.init = bus_wdata[CNT_W-1:0];
            end
            if (bus_addr == OFS_DIV) begin
                st_d.div = {bus_wdata[3], bus_wdata[1:0]};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.cfg.mask <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_CFG: begin
                bus_rdata[VEC_W-1:0]           = st_q.cfg.vec;
                bus_rdata[CFG_MASK_BIT]        = st_q.cfg.mask;
                bus_rdata[CFG_MODE_LSB +: 2]   = st_q.cfg.mode;
            end
            OFS_INIT: bus_rdata[CNT_W-1:0] = st_q.init;
            OFS_CUR:  bus_rdata[CNT_W-1:0] = cur_count;
            OFS_DIV: begin
                bus_rdata[3]   = st_q.div[2];
                bus_rdata[1:0] = st_q.div[1:0];
            end
            default: bus_rdata = '0;
        endcase
    end

    assign init_wr    = bus_wr && (bus_addr == OFS_INIT);
    assign init_wdata = bus_wdata[CNT_W-1:0];
    assign cfg        = st_q.cfg;
    assign init_cnt   = st_q.init;
    assign div_code   = st_q.div;
endmodule

// File: rtl/cdt_prescaler.sv
module cdt_prescaler #(
    parameter int PRE_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             restart,
    input  logic [PRE_W-1:0] limit,
    output logic             tick
);
    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_st_t;

    pre_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = 1'b0;
        if (restart || !enable) begin
            st_d.cnt = '0;
        end else if (st_q.cnt >= limit) begin
            // >= keeps the prescaler from overrunning if the code shrinks mid-count
            st_d.cnt = '0;
            tick     = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/cdt_counter.sv
module cdt_counter #(
    parameter int CNT_W = 32,
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             periodic,
    input  logic             masked,
    input  logic [VEC_W-1:0] vec,
    input  logic             tick,
    output logic [CNT_W-1:0] cur_count,
    output logic             running,
    output logic             irq_valid,
    output logic [VEC_W-1:0] irq_vector
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cur;
        logic             run;
        logic             irq;
        logic [VEC_W-1:0] vec;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        if (load) begin
            st_d.cur = load_val;
            st_d.run = |load_val;
        end else if (st_q.run && tick) begin
            if (st_q.cur == ONE) begin
                st_d.irq = !masked;
                st_d.vec = vec;
                if (periodic) begin
                    st_d.cur = reload_val;
                end else begin
                    st_d.cur = '0;
                    st_d.run = 1'b0;
                end
            end else begin
                st_d.cur = st_q.cur - ONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cur_count  = st_q.cur;
    assign running    = st_q.run;
    assign irq_valid  = st_q.irq;
    assign irq_vector = st_q.vec;
endmodule

// File: rtl/cdt_timer.sv
module cdt_timer #(
    parameter int CNT_W = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [cdt_pkg::ADDR_W-1:0]  bus_addr,
    input  logic                        bus_wr,
    input  logic [cdt_pkg::DATA_W-1:0]  bus_wdata,
    output logic [cdt_pkg::DATA_W-1:0]  bus_rdata,
    output logic                        irq_valid,
    output logic [cdt_pkg::VEC_W-1:0]   irq_vector
);
    import cdt_pkg::*;

    cfg_t             cfg;
    logic [CNT_W-1:0] init_cnt;
    logic [CNT_W-1:0] init_wdata;
    logic [CNT_W-1:0] cur_count;
    logic [2:0]       div_code;
    logic             init_wr;
    logic             running;
    logic             cfg_mask;
    logic             periodic;
    logic             tick;
    logic [PRE_W-1:0] limit;

    assign cfg_mask = cfg.mask;
    assign periodic = (cfg.mode == MODE_PERIODIC);
    assign limit    = div_limit(div_code);

    cdt_regs #(.CNT_W(CNT_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_wdata  (bus_wdata),
        .cur_count  (cur_count),
        .cfg        (cfg),
        .init_cnt   (init_cnt),
        .div_code   (div_code),
        .init_wr    (init_wr),
        .init_wdata (init_wdata),
        .bus_rdata  (bus_rdata)
    );

    cdt_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (running),
        .restart (init_wr),
        .limit   (limit),
        .tick    (tick)
    );

    cdt_counter #(.CNT_W(CNT_W), .VEC_W(VEC_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (init_wr),
        .load_val   (init_wdata),
        .reload_val (init_cnt),
        .periodic   (periodic),
        .masked     (cfg_mask),
        .vec        (cfg.vec),
        .tick       (tick),
        .cur_count  (cur_count),
        .running    (running),
        .irq_valid  (irq_valid),
        .irq_vector (irq_vector)
    );
endmodule

// File: rtl/cdt_timer_chk.sv
module cdt_timer_chk #(
    parameter int CNT_W = 32
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        bus_wr,
    input logic [cdt_pkg::ADDR_W-1:0]  bus_addr,
    input logic [cdt_pkg::DATA_W-1:0]  bus_wdata,
    input logic [CNT_W-1:0]            cur_count,
    input logic [CNT_W-1:0]            init_cnt,
    input logic                        running,
    input logic                        cfg_mask,
    input logic                        irq_valid
);
    import cdt_pkg::*;

    AST_LOAD_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_INIT && bus_wdata[CNT_W-1:0] != '0)
        |=> (running && cur_count == $past(bus_wdata[CNT_W-1:0]))); // R3

    AST_ZERO_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_INIT && bus_wdata[CNT_W-1:0] == '0)
        |=> (!running && cur_count == '0)); // R3

    AST_MASK_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> !$past(cfg_mask)); // R7

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !running |=> !irq_valid); // R8

    AST_COUNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (cur_count != '0 && cur_count <= init_cnt)); // R6
endmodule

bind cdt_timer cdt_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .cur_count (cur_count),
    .init_cnt  (init_cnt),
    .running   (running),
    .cfg_mask  (cfg_mask),
    .irq_valid (irq_valid)
);

// File: tb/cdt_timer_test.sv
module cdt_timer_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [11:0] bus_addr;
    logic        bus_wr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        irq_valid;
    logic [7:0]  irq_vector;

    localparam logic [11:0] A_CFG = 12'h320, A_INIT = 12'h380,
                            A_CUR = 12'h390, A_DIV = 12'h3E0;

    always #10 clk = ~clk;

    cdt_timer uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_valid(irq_valid), .irq_vector(irq_vector)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int fails  = 0;
    int exp_cyc[$];
    logic [7:0] exp_vec[$];
    int mon_c;
    logic [7:0] mon_v;
    bit done = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Scoreboard monitor: pops the expected request list as requests appear.
    always @(negedge clk) begin
        if (rst_n) begin
            if (irq_valid) begin
                checks++;
                if (exp_cyc.size() == 0) begin
                    fails++;
                    $display("FAIL R9 unexpected request actual=cycle %0d vec %0h expected=none",
                             cyc, irq_vector);
                end else begin
                    mon_c = exp_cyc.pop_front();
                    mon_v = exp_vec.pop_front();
                    if (mon_c != cyc || mon_v !== irq_vector) begin
                        fails++;
                        $display("FAIL R9 request actual=cycle %0d vec %0h expected=cycle %0d vec %0h",
                                 cyc, irq_vector, mon_c, mon_v);
                    end
                end
            end else if (exp_cyc.size() != 0 && exp_cyc[0] < cyc) begin
                checks++;
                fails++;
                $display("FAIL R9 missed request actual=none expected=cycle %0d vec %0h",
                         exp_cyc[0], exp_vec[0]);
                void'(exp_cyc.pop_front());
                void'(exp_vec.pop_front());
            end
        end
    end

    task automatic push_irq(input int c, input logic [7:0] v);
        exp_cyc.push_back(c);
        exp_vec.push_back(v);
    endtask

    // Returns at the negedge right after the write edge; wedge is that edge's cycle.
    task automatic bwrite(input logic [11:0] a, input logic [31:0] d, output int wedge);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        wedge     = cyc + 1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic bread(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_to(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        int w;
        int codes[8] = '{32'h0, 32'h1, 32'h2, 32'h3, 32'h8, 32'h9, 32'hA, 32'hB};
        int divs[8]  = '{2, 4, 8, 16, 32, 64, 128, 1};

        rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset values
        bread(A_CFG, rd);  chk("R10 cfg reset", rd, 32'h0001_0000);
        bread(A_INIT, rd); chk("R10 init reset", rd, 0);
        bread(A_CUR, rd);  chk("R10 cur reset", rd, 0);
        bread(A_DIV, rd);  chk("R10 div reset", rd, 0);

        // R1 / R2 field layout
        bwrite(A_CFG, 32'hFFFF_FFFF, w);
        bread(A_CFG, rd); chk("R1 cfg readback", rd, 32'h0007_00FF);
        bwrite(A_DIV, 32'hFFFF_FFFF, w);
        bread(A_DIV, rd); chk("R2 div readback", rd, 32'h0000_000B);

        // R4 divider sweep (masked one-shot, so no requests)
        for (int i = 0; i < 8; i++) begin
            bwrite(A_DIV, codes[i], w);
            bwrite(A_INIT, 100, w);
            wait_to(w + divs[i] - 1);
            bread(A_CUR, rd); chk($sformatf("R4 code %0h before first tick", codes[i]), rd, 100);
            wait_to(w + divs[i]);
            bread(A_CUR, rd); chk($sformatf("R4 code %0h first tick", codes[i]), rd, 99);
            wait_to(w + 4 * divs[i]);
            bread(A_CUR, rd); chk($sformatf("R4 code %0h fourth tick", codes[i]), rd, 96);
            bwrite(A_INIT, 0, w);
        end

        // R3 stop by writing zero, unmasked one-shot
        bwrite(A_DIV, 32'hB, w);
        bwrite(A_CFG, 32'h0000_0031, w);
        bwrite(A_INIT, 50, w);
        wait_to(w + 5);
        bread(A_CUR, rd); chk("R3 counting", rd, 45);
        bwrite(A_INIT, 0, w);
        bread(A_CUR, rd); chk("R3 stopped", rd, 0);
        wait_to(w + 70);
        bread(A_CUR, rd); chk("R3 still stopped", rd, 0);

        // R8 / R9 one-shot fires once, holds zero, re-arms on write
        bwrite(A_INIT, 5, w);
        push_irq(w + 5, 8'h31);
        wait_to(w + 30);
        bread(A_CUR, rd); chk("R8 one-shot holds zero", rd, 0);
        chk("R9 one-shot request delivered", exp_cyc.size(), 0);
        bwrite(A_INIT, 3, w);
        push_irq(w + 3, 8'h31);
        wait_to(w + 12);
        chk("R8 re-armed request delivered", exp_cyc.size(), 0);

        // R5 periodic, divide by 2, count 4
        bwrite(A_CFG, 32'h0002_0030, w);
        bwrite(A_DIV, 32'h0, w);
        bwrite(A_INIT, 4, w);
        push_irq(w + 8, 8'h30);
        push_irq(w + 16, 8'h30);
        push_irq(w + 24, 8'h30);
        wait_to(w + 7);
        bread(A_CUR, rd); chk("R5 count at one", rd, 1);
        wait_to(w + 8);
        bread(A_CUR, rd); chk("R5 reloaded", rd, 4);
        wait_to(w + 25);
        bwrite(A_INIT, 0, w);
        chk("R5 periodic requests delivered", exp_cyc.size(), 0);

        // R7 masked periodic keeps counting, no requests
        bwrite(A_CFG, 32'h0003_0030, w);
        bwrite(A_DIV, 32'hB, w);
        bwrite(A_INIT, 3, w);
        wait_to(w + 4);
        bread(A_CUR, rd); chk("R7 masked counter reloads", rd, 2);
        wait_to(w + 20);
        bread(A_CUR, rd); chk("R7 masked still running", rd, 3 - ((20 - 3) % 3) == 3 ? 32'd3 : 32'(3 - (20 % 3)));
        bwrite(A_INIT, 0, w);

        // R6 current count is read-only; elapsed ticks
        bwrite(A_CUR, 77, w);
        bread(A_CUR, rd);  chk("R6 cur write ignored", rd, 0);
        bread(A_INIT, rd); chk("R6 init untouched by cur write", rd, 0);
        bwrite(A_CFG, 32'h0001_0000, w);
        bwrite(A_INIT, 200, w);
        wait_to(w + 37);
        bread(A_CUR, rd); chk("R6 elapsed ticks", 200 - rd, 37);
        bwrite(A_INIT, 0, w);

        repeat (5) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule